// File: doc/BRIEF.md
# Per-Instruction Elastic Clock Divider

This block derives a slow output clock from a fast, free-running input clock, where the length of every output half-period is chosen by the instruction currently being executed. Each opcode owns an entry in a small rewritable table of counts. A counter runs on every rising edge of the fast clock. When it completes the count held for the current half-period, it clears and the output level flips.

The opcode is looked up only at the edge where the output flips, and at the final edge of reset. The count found there is latched for the whole of the following half-period. A processor can therefore get a short clock phase for simple instructions and a long one for slow instructions. Software can retune the counts at run time through the write port.

A stored count of zero behaves as one, so the shortest half-period is a single fast cycle and the output never stalls.

Top module: `instr_elastic_clkgen`

## Requirements
- R1: While reset is high at a rising edge of `clk_fast`, `clk_out` is driven low and the phase counter is cleared. The count for the first half-period after reset is taken from the entry addressed by `op_code` at the last edge on which reset was high.
- R2: Each half-period of `clk_out` (high or low) lasts exactly N rising edges of `clk_fast`, where N is the latched count for that half-period. For a constant opcode, the high and low phases are therefore equal (50% duty cycle).
- R3: `op_code` is sampled only at the edge on which `clk_out` flips and at the last reset edge. A change of `op_code` between those edges does not shorten or stretch the half-period in progress.
- R4: A table entry of value 0 is treated as 1, so `clk_out` flips on every rising edge of `clk_fast` while that entry is in use.
- R5: A table write (`tbl_we` high at a rising edge) stores `tbl_data` at `tbl_addr`. It affects only half-periods whose count is looked up after that edge. It never alters a half-period already in progress, and a lookup made on the same edge as the write returns the previous content.
- R6: The table has 16 independent 8-bit entries indexed by the 4-bit opcode value (entry k serves opcode k). Writing one entry leaves every other entry unchanged. The maximum count, 255, gives a half-period of 255 fast cycles.
- R7: Out of reset, the phase counter never reaches the latched count, and it returns to zero on the edge after it equals the latched count minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast free-running input clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | OPC_W (4) | Opcode of the instruction being executed |
| tbl_addr | input | OPC_W (4) | Table entry to write |
| tbl_data | input | CNT_W (8) | Count value to write |
| tbl_we | input | 1 | Table write enable |
| clk_out | output | 1 | Generated elastic clock, registered |

## Verification
A flip of `clk_out` becomes visible right after the rising edge that completes N counts, where N is looked up at the previous flip. This is a single register stage, so the bench samples on falling edges only. It counts the rising edges between two observed output changes and compares that figure with N. The bench takes N from its own copy of the table, indexed by the opcode it held at the rising edge where the previous flip occurred. A write made on that same edge is folded into the copy only after the lookup, which matches the one-edge delay of the write port. If the bench sees no flip once the expected count has elapsed, it reports a stall in the same cycle.

// File: rtl/eclk_pkg.sv
package eclk_pkg;
  localparam int OPC_W_DEF = 4;
  localparam int CNT_W_DEF = 8;

  // saturate a stored count so that zero behaves as one
  function automatic logic [CNT_W_DEF-1:0] eff_count(input logic [CNT_W_DEF-1:0] raw);
    return (raw == '0) ? CNT_W_DEF'(1) : raw;
  endfunction
endpackage

// File: rtl/eclk_count_table.sv
module eclk_count_table #(
  parameter int OPC_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OPC_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [OPC_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << OPC_W;

  logic [CNT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eclk_limit_latch.sv
module eclk_limit_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [CNT_W-1:0] raw_count,
  output logic [CNT_W-1:0] limit_q
);
  localparam logic [CNT_W-1:0] MIN_COUNT = CNT_W'(1);

  logic [CNT_W-1:0] sat_count;

  always_comb begin
    sat_count = (raw_count == '0) ? MIN_COUNT : raw_count;
  end

  always_ff @(posedge clk) begin
    if (rst || reload) limit_q <= sat_count;
  end
endmodule

// File: rtl/eclk_phase_counter.sv
module eclk_phase_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  always_comb begin
    wrap = (cnt_q == (limit - STEP));
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + STEP;
  end
endmodule

// File: rtl/eclk_toggle_out.sv
module eclk_toggle_out (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic level_q
);
  always_ff @(posedge clk) begin
    if (rst)       level_q <= 1'b0;
    else if (flip) level_q <= ~level_q;
  end
endmodule

// File: rtl/instr_elastic_clkgen.sv
module instr_elastic_clkgen #(
  parameter int OPC_W = eclk_pkg::OPC_W_DEF,
  parameter int CNT_W = eclk_pkg::CNT_W_DEF
) (
  input  logic             clk_fast,
  input  logic             rst,
  input  logic [OPC_W-1:0] op_code,
  input  logic [OPC_W-1:0] tbl_addr,
  input  logic [CNT_W-1:0] tbl_data,
  input  logic             tbl_we,
  output logic             clk_out
);
  logic [CNT_W-1:0] table_rd;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  eclk_count_table #(.OPC_W(OPC_W), .CNT_W(CNT_W)) u_table (
    .clk     (clk_fast),
    .we      (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_data),
    .rd_addr (op_code),
    .rd_data (table_rd)
  );

  eclk_limit_latch #(.CNT_W(CNT_W)) u_limit (
    .clk       (clk_fast),
    .rst       (rst),
    .reload    (wrap),
    .raw_count (table_rd),
    .limit_q   (lim_q)
  );

  eclk_phase_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk_fast),
    .rst   (rst),
    .limit (lim_q),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  eclk_toggle_out u_toggle (
    .clk     (clk_fast),
    .rst     (rst),
    .flip    (wrap),
    .level_q (clk_out)
  );
endmodule

// File: rtl/eclk_checker.sv
module eclk_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim
);
  localparam logic [CNT_W-1:0] UNIT = CNT_W'(1);

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (clk_out == 1'b0));

  // R7
  cnt_below_lim_chk: assert property (@(posedge clk) disable iff (rst) (cnt < lim));

  // R7
  cnt_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == (lim - UNIT)) |=> (cnt == '0));

  // R2
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != (lim - UNIT)) |=> $stable(clk_out));

  // R2
  flip_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == (lim - UNIT)) |=> (clk_out != $past(clk_out)));

  // R3
  lim_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != (lim - UNIT)) |=> $stable(lim));
endmodule

bind instr_elastic_clkgen eclk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_fast),
  .rst     (rst),
  .clk_out (clk_out),
  .cnt     (cnt_q),
  .lim     (lim_q)
);

// File: tb/instr_elastic_clkgen_bench.sv
module instr_elastic_clkgen_bench;
  logic       clk_fast = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = 4'd0;
  logic [3:0] tbl_addr = 4'd0;
  logic [7:0] tbl_data = 8'd0;
  logic       tbl_we = 1'b0;
  logic       clk_out;

  instr_elastic_clkgen u_instr_elastic_clkgen (
    .clk_fast (clk_fast),
    .rst      (rst),
    .op_code  (op_code),
    .tbl_addr (tbl_addr),
    .tbl_data (tbl_data),
    .tbl_we   (tbl_we),
    .clk_out  (clk_out)
  );

  always #5 clk_fast = ~clk_fast;

  int checks = 0;
  int fails = 0;
  int halves = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R2";

  // bench model of the table
  int btab [16];
  bit armed = 0;
  bit rst_d = 0;
  int run = 0;
  int exp_len = 1;
  logic prev_lvl = 1'b0;
  logic [3:0] op_last = 4'd0;
  bit pend_we = 0;
  logic [3:0] pend_addr = 4'd0;
  logic [7:0] pend_data = 8'd0;

  // {opcode, dwell cycles}
  localparam logic [11:0] SEQ [12] = '{
    {4'd1, 8'd30}, {4'd3, 8'd20}, {4'd8, 8'd12}, {4'd2, 8'd40},
    {4'd13, 8'd9}, {4'd6, 8'd25}, {4'd10, 8'd50}, {4'd0, 8'd7},
    {4'd11, 8'd33}, {4'd4, 8'd18}, {4'd14, 8'd27}, {4'd7, 8'd44}
  };

  function automatic int tval(input int i);
    if (i == 5) return 0;
    if (i == 15) return 255;
    return (i * 5) % 13 + 1;
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor on falling edges
  always @(negedge clk_fast) begin
    if (rst) begin
      if (rst_d) check(clk_out === 1'b0, "R1", int'(clk_out), 0);
      armed = 0;
    end else if (!armed) begin
      armed = 1;
      run = 0;
      exp_len = eff(btab[op_last]);
      prev_lvl = clk_out;
      check(clk_out === 1'b0, "R1", int'(clk_out), 0);
    end else begin
      run++;
      if (clk_out !== prev_lvl) begin
        check(run == exp_len, tag, run, exp_len);
        halves++;
        exp_len = eff(btab[op_last]);
        run = 0;
        prev_lvl = clk_out;
      end else if (run >= exp_len) begin
        check(1'b0, "R7", run + 1, exp_len);
        run = 0;
      end
    end
    if (pend_we) btab[pend_addr] = int'(pend_data);
    pend_we = tbl_we;
    pend_addr = tbl_addr;
    pend_data = tbl_data;
    rst_d = rst;
    op_last = op_code;
  end

  task automatic drive_op(input logic [3:0] op, input int n);
    @(posedge clk_fast); #2;
    op_code = op;
    repeat (n) @(posedge clk_fast);
  endtask

  task automatic tbl_wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk_fast); #2;
    tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(posedge clk_fast); #2;
    tbl_we = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk_fast) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      check(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) btab[i] = 0;
    // R6: load all 16 entries while in reset
    for (int i = 0; i < 16; i++) tbl_wr(4'(i), 8'(tval(i)));
    drive_op(4'd7, 3);
    @(posedge clk_fast); #2 rst = 1'b0;

    // vector walk, R2
    tag = "R2";
    for (int k = 0; k < 12; k++) drive_op(SEQ[k][11:8], int'(SEQ[k][7:0]));

    // R3: opcode changes in the middle of a long phase
    tag = "R3";
    drive_op(4'd10, 30);
    for (int k = 0; k < 8; k++) drive_op(4'(k), 3);
    drive_op(4'd2, 40);

    // R5: rewrite the active entry mid-phase
    tag = "R5";
    drive_op(4'd2, 5);
    tbl_wr(4'd2, 8'd4);
    drive_op(4'd2, 30);
    tbl_wr(4'd2, 8'd17);
    drive_op(4'd2, 60);

    // R6: neighbours unaffected by a write
    tag = "R6";
    tbl_wr(4'd3, 8'd2);
    drive_op(4'd4, 30);
    drive_op(4'd3, 20);
    drive_op(4'd15, 600);

    // R4: zero entry gives one-cycle half-periods
    tag = "R4";
    drive_op(4'd5, 20);
    tbl_wr(4'd9, 8'd0);
    drive_op(4'd9, 20);

    // R1: reset in mid-run, restart with a new opcode
    tag = "R1";
    @(posedge clk_fast); #2 rst = 1'b1; op_code = 4'd6;
    repeat (3) @(posedge clk_fast);
    #2 rst = 1'b0;
    drive_op(4'd6, 40);
    drive_op(4'd1, 20);

    check(halves >= 60, "R2", halves, 60);
    repeat (4) @(posedge clk_fast);
    finish_run();
  end
endmodule